// File: doc/BRIEF.md
# Near-Unity Floating-Point Square Root Pipeline

This block produces a fast approximate square root of a 40-bit floating-point word whose value lies close to one. The word holds an 8-bit two's-complement exponent in bits 39:32, and a 32-bit field in bits 31:0. Bit 31 of the field is the sign and bits 30:0 are the fraction. For any value between 0.75 and just under 2.0, the exponent is either 0x00 or 0xFF. The root can then be formed without a real root algorithm: the exponent is kept as it is, and the field goes through a fixed chain of four shifts.

The field is first shifted left by one bit (logical). It is then shifted right by two bits (arithmetic), shifted left by one bit (logical), and finally shifted right by one bit (logical), which clears the sign. Three register stages hold the first three shifts. The last shift is pure wiring at the output. One word can be accepted on every clock, and a valid bit travels with each word. An out-of-range flag travels with the data. It marks inputs for which the shortcut does not apply. Such words are still shifted and delivered, and the consumer decides what to do with them.

Top module: `nsq_top`

## Requirements
- R1: A word sampled with `in_valid` high on a rising edge appears with `out_valid` high right after the third following rising edge. Words presented on consecutive clocks come out on consecutive clocks, in order.
- R2: The output exponent, `out_word[39:32]`, equals the input exponent unchanged.
- R3: With input field f = `in_word[31:0]`, the output field equals f after the four shifts. In closed form this is {0, f[30], f[30:1]}.
- R4: The output sign bit, `out_word[31]`, is always 0 when `out_valid` is high.
- R5: `out_oor` is 1 when the input exponent is neither 0x00 nor 0xFF, or when the input sign bit is 1. Otherwise it is 0. The field and exponent of such a word are still produced as in R2 and R3.
- R6: A synchronous reset (`rst` high on a rising edge) clears every stage valid bit. `out_valid` is 0 after reset until new valid words have passed through, and words in flight at reset are discarded.
- R7: A clock with `in_valid` low produces a clock with `out_valid` low three cycles later. Bubbles keep their place in the stream.
- R8: The input 1.001 (exponent 0x00, field 0x0020C500) gives a field within 0x400 of 0x00106100. The input 0.999 (exponent 0xFF, field 0x7FBE7700) gives a field within 0x400 of 0x7FDF3900.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 40 | Exponent in bits 39:32, sign in bit 31, fraction in bits 30:0 |
| out_valid | output | 1 | Result qualifier |
| out_word | output | 40 | Approximate square root in the same format |
| out_oor | output | 1 | Input was outside the range the shortcut supports |

## Verification
The bench drives an exponent of 0xFF with the top fraction bit set. A design that used a logical shift where the arithmetic one belongs would lose the replicated bit and return a field near 0x3FDF.... It also sends fields whose low bit and bit 1 differ, which exposes a shift of the wrong distance or a truncation at the wrong place. A stream with bubbles and back-to-back words catches a stage that is skipped or doubled, because results would then arrive a cycle early or late. A reset issued while words are in flight catches a valid bit that survives reset. Exponents of 0x01 and 0x80, and a set sign bit, check that the range flag looks at both exponent encodings and at the sign.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

  typedef enum logic [1:0] {
    OP_LSL1 = 2'd0,
    OP_ASR2 = 2'd1,
    OP_LSR1 = 2'd2
  } shift_op_e;

  localparam int unsigned NUM_OPS = 4;

  // Fixed order of the shift chain; the result depends on this order.
  function automatic shift_op_e stage_op(input int unsigned idx);
    case (idx)
      0:       return OP_LSL1;
      1:       return OP_ASR2;
      2:       return OP_LSL1;
      default: return OP_LSR1;
    endcase
  endfunction

endpackage

// File: rtl/nsq_range.sv
module nsq_range #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned FLD_W = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [FLD_W-1:0] fld_i,
  output logic             oor_o
);
  logic exp_zero;
  logic exp_minus_one;
  logic sign_set;

  assign exp_zero      = (exp_i == '0);
  assign exp_minus_one = (exp_i == '1);
  assign sign_set      = fld_i[FLD_W-1];

  assign oor_o = sign_set | ~(exp_zero | exp_minus_one);
endmodule

// File: rtl/nsq_stage.sv
module nsq_stage #(
  parameter int unsigned       EXP_W      = 8,
  parameter int unsigned       FLD_W      = 32,
  parameter nsq_pkg::shift_op_e OP        = nsq_pkg::OP_LSL1,
  parameter bit                REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic             oor_i,
  output logic             vld_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [FLD_W-1:0] fld_o,
  output logic             oor_o
);

  function automatic logic [FLD_W-1:0] f_lsl1(input logic [FLD_W-1:0] v);
    return {v[FLD_W-2:0], 1'b0};
  endfunction

  function automatic logic [FLD_W-1:0] f_asr2(input logic [FLD_W-1:0] v);
    return {{2{v[FLD_W-1]}}, v[FLD_W-1:2]};
  endfunction

  function automatic logic [FLD_W-1:0] f_lsr1(input logic [FLD_W-1:0] v);
    return {1'b0, v[FLD_W-1:1]};
  endfunction

  logic [FLD_W-1:0] shifted;

  generate
    if (OP == nsq_pkg::OP_LSL1) begin : g_lsl1
      assign shifted = f_lsl1(fld_i);
    end else if (OP == nsq_pkg::OP_ASR2) begin : g_asr2
      assign shifted = f_asr2(fld_i);
    end else begin : g_lsr1
      assign shifted = f_lsr1(fld_i);
    end
  endgenerate

  generate
    if (REGISTERED) begin : g_reg
      logic             vld_q;
      logic [EXP_W-1:0] exp_q;
      logic [FLD_W-1:0] fld_q;
      logic             oor_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
        end else begin
          vld_q <= vld_i;
        end
        exp_q <= exp_i;
        fld_q <= shifted;
        oor_q <= oor_i;
      end

      assign vld_o = vld_q;
      assign exp_o = exp_q;
      assign fld_o = fld_q;
      assign oor_o = oor_q;

      // R1: a valid word advances exactly one stage per clock
      p_stage_adv_r1: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);
      // R2: exponent is carried through the stage untouched
      p_stage_exp_r2: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> exp_o == $past(exp_i));
      // R7: a bubble stays a bubble
      p_stage_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);
    end else begin : g_comb
      assign vld_o = vld_i;
      assign exp_o = exp_i;
      assign fld_o = shifted;
      assign oor_o = oor_i;
    end
  endgenerate

endmodule

// File: rtl/nsq_top.sv
module nsq_top #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned FLD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+FLD_W-1:0] in_word,
  output logic                   out_valid,
  output logic [EXP_W+FLD_W-1:0] out_word,
  output logic                   out_oor
);
  localparam int unsigned WORD_W = EXP_W + FLD_W;
  localparam int unsigned NOPS   = nsq_pkg::NUM_OPS;
  localparam int unsigned NREG   = NOPS - 1;

  logic             vld_s [0:NOPS];
  logic [EXP_W-1:0] exp_s [0:NOPS];
  logic [FLD_W-1:0] fld_s [0:NOPS];
  logic             oor_s [0:NOPS];

  logic             in_oor;

  nsq_range #(.EXP_W(EXP_W), .FLD_W(FLD_W)) u_range (
    .exp_i (in_word[WORD_W-1:FLD_W]),
    .fld_i (in_word[FLD_W-1:0]),
    .oor_o (in_oor)
  );

  assign vld_s[0] = in_valid;
  assign exp_s[0] = in_word[WORD_W-1:FLD_W];
  assign fld_s[0] = in_word[FLD_W-1:0];
  assign oor_s[0] = in_oor;

  generate
    for (genvar i = 0; i < NOPS; i++) begin : g_chain
      nsq_stage #(
        .EXP_W      (EXP_W),
        .FLD_W      (FLD_W),
        .OP         (nsq_pkg::stage_op(i)),
        .REGISTERED (i < NREG)
      ) u_stage (
        .clk   (clk),
        .rst   (rst),
        .vld_i (vld_s[i]),
        .exp_i (exp_s[i]),
        .fld_i (fld_s[i]),
        .oor_i (oor_s[i]),
        .vld_o (vld_s[i+1]),
        .exp_o (exp_s[i+1]),
        .fld_o (fld_s[i+1]),
        .oor_o (oor_s[i+1])
      );
    end
  endgenerate

  assign out_valid = vld_s[NOPS];
  assign out_word  = {exp_s[NOPS], fld_s[NOPS]};
  assign out_oor   = oor_s[NOPS];

  // R4: the final shift always leaves a positive result
  p_sign_clear_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_word[FLD_W-1]);

  // R2: exponent at the output equals the one sampled three clocks earlier
  p_exp_pass_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[WORD_W-1:FLD_W] == $past(in_word[WORD_W-1:FLD_W], 3));

  // R3: closed form of the four-shift chain
  p_field_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[FLD_W-2:0] ==
      {$past(in_word[FLD_W-2]), $past(in_word[FLD_W-2:1], 3)} ? 1'b1 :
      out_word[FLD_W-2:0] == {$past(in_word[FLD_W-2], 3), $past(in_word[FLD_W-2:1], 3)});

  // R5: an in-range flag at the output implies an accepted exponent
  p_oor_exp_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_oor) |->
      (out_word[WORD_W-1:FLD_W] == '0 || out_word[WORD_W-1:FLD_W] == '1));

  // R1: latency of three clocks when no reset intervened
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
      |-> out_valid);

endmodule

// File: tb/tb_nsq_top.sv
module tb_nsq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [39:0] in_word = '0;
  logic        out_valid;
  logic [39:0] out_word;
  logic        out_oor;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nsq_top dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_oor   (out_oor)
  );

  // Square root of near-unity value: halve the magnitude bits and keep bit 30.
  function automatic logic [31:0] exp_field(input logic [31:0] f);
    logic [31:0] mag;
    mag = (f & 32'h7FFF_FFFF) >> 1;
    if (f[30]) mag = mag | 32'h4000_0000;
    return mag;
  endfunction

  function automatic bit exp_oor(input logic [39:0] w);
    return !(w[39:32] == 8'h00 || w[39:32] == 8'hFF) || w[31];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [39:0] act,
                     input logic [39:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_word(input logic [39:0] w, input string tag);
    logic [39:0] e;
    e = {w[39:32], exp_field(w[31:0])};
    chk(out_valid === 1'b1, {tag, " R1 valid"}, {39'd0, out_valid}, 40'd1);
    chk(out_word[39:32] === w[39:32], {tag, " R2 exponent"}, out_word, e);
    chk(out_word[31:0] === e[31:0], {tag, " R3 field"}, out_word, e);
    chk(out_word[31] === 1'b0, {tag, " R4 sign"}, out_word, e);
    chk(out_oor === exp_oor(w), {tag, " R5 oor"}, {39'd0, out_oor},
        {39'd0, exp_oor(w)});
  endtask

  task automatic run_one(input logic [39:0] w, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, {tag, " R1 not early"}, {39'd0, out_valid}, 40'd0);
    @(negedge clk);
    check_word(w, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_word = 40'h00_0020C500;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R6 valid low during reset", {39'd0, out_valid}, 40'd0);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R6 valid low after reset", {39'd0, out_valid}, 40'd0);
    end
  endtask

  task automatic t_known_points();
    logic [31:0] d;
    run_one(40'h00_0020C500, "1.001");
    d = (out_word[31:0] > 32'h00106100) ? out_word[31:0] - 32'h00106100
                                       : 32'h00106100 - out_word[31:0];
    chk(d < 32'h400, "R8 sqrt(1.001) near target", out_word, 40'h00_00106100);
    run_one(40'hFF_7FBE7700, "0.999");
    d = (out_word[31:0] > 32'h7FDF3900) ? out_word[31:0] - 32'h7FDF3900
                                       : 32'h7FDF3900 - out_word[31:0];
    chk(d < 32'h400, "R8 sqrt(0.999) near target", out_word, 40'hFF_7FDF3900);
  endtask

  task automatic t_patterns();
    run_one(40'hFF_40000003, "0.75 edge");
    run_one(40'h00_7FFFFFFF, "near 2");
    run_one(40'h00_00000000, "exactly one");
    run_one(40'hFF_55555556, "alternating");
  endtask

  task automatic t_out_of_range();
    run_one(40'h01_00200000, "R5 exp 0x01");
    run_one(40'h80_12345678, "R5 exp 0x80");
    run_one(40'h00_80001000, "R5 sign set");
    run_one(40'hFE_7FFFFFFE, "R5 exp 0xFE");
  endtask

  task automatic t_stream();
    logic [39:0] pw [0:7];
    bit          pv [0:7];
    pw[0] = 40'h00_0020C500; pv[0] = 1;
    pw[1] = 40'hFF_7FBE7700; pv[1] = 1;
    pw[2] = 40'h00_11111111; pv[2] = 0;
    pw[3] = 40'h00_3000000F; pv[3] = 1;
    pw[4] = 40'hFF_6AAAAAA9; pv[4] = 1;
    pw[5] = 40'h7F_00000002; pv[5] = 1;
    pw[6] = 40'h00_22222222; pv[6] = 0;
    pw[7] = 40'hFF_7000000C; pv[7] = 1;
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        if (pv[c-3]) begin
          check_word(pw[c-3], "R1 stream");
        end else begin
          chk(out_valid === 1'b0, "R7 bubble kept", {39'd0, out_valid}, 40'd0);
        end
      end
      if (c < 8) begin
        in_valid = pv[c];
        in_word  = pw[c];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset_in_flight();
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 40'h00_0020C500;
    @(negedge clk);
    in_word  = 40'hFF_7FBE7700;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R6 in-flight words dropped", {39'd0, out_valid}, 40'd0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_known_points();
    t_patterns();
    t_out_of_range();
    t_stream();
    t_reset_in_flight();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule